// File: doc/BRIEF.md
# Reload-on-Overflow PWM Timer

This block is a free-running up-counter that drives a single pulse-width-modulated output. Software programs a start value, a compare value and a two-bit control word through a simple write port. The counter climbs one step per clock. When it passes its all-ones value it restarts from the start value and the output rises. The output falls when the count reaches the compare value. The period in clocks is therefore 2^WIDTH minus the start value, and the high time is the compare value minus the start value.

The start value is read only when the counter restarts, so rewriting it never disturbs the cycle in progress. The compare value is checked against the count on every clock. A compare value rewritten during the high phase can therefore shorten that phase, or stretch it across the wrap into the next cycle. No mechanism is provided to hold such writes back; the block exposes this behaviour deliberately.

Top module: `pwm_reload_timer`

## Requirements
- R1: After reset the count is 0, the output is low, the timer is stopped, auto-restart is off, and the start and compare values are 0.
- R2: A write with `wr_en` high is decoded on `wr_addr`: code 0 is the control word (bit 0 run, bit 1 auto-restart), code 1 the start value, code 2 the compare value; code 3 is ignored.
- R3: A control write that sets the run bit while the timer is stopped loads the count with the stored start value and drives the output low at that clock edge; counting begins on the next clock.
- R4: While running, the count rises by one per clock; clearing the run bit freezes the count and the output level.
- R5: With auto-restart on, the clock edge after the count is all-ones loads the start value and drives the output high.
- R6: The output falls at the edge where the count steps onto the compare value, so with steady settings the output is high for (compare - start) clocks and low for (2^WIDTH - compare) clocks.
- R7: A new start value leaves the running count untouched and is used first at the next wrap.
- R8: A compare value written during the high phase that lies above the current count ends that high phase when the count reaches the new value.
- R9: A compare value written during the high phase that lies below the current count keeps the output high through the wrap until the new value is reached in the following cycle.
- R10: A compare value written during the low phase does not change that low phase; it sets the high time of the next cycle.
- R11: With auto-restart off, the count stops at all-ones, the run bit clears, the output keeps its level, and a later run write restarts from the start value.
- R12: When the compare value equals the start value, the wrap takes precedence and the output stays high continuously.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select code |
| wr_data | input | WIDTH | Write data |
| count_o | output | WIDTH | Current counter value |
| pwm_o | output | 1 | PWM output level |

## Verification
Two functions can act in the same clock edge: the wrap that raises the output and the compare hit that lowers it. The bench provokes this by setting the compare value equal to the start value, then confirms that the output never goes low over several whole periods. A further case occurs when a compare write arrives in the cycle the count passes it. The bench writes compare values at chosen counts in both phases and compares the lengths of the following high and low runs with values computed from R8, R9 and R10. A behavioural model in the bench also checks count and level on every clock.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    // register select codes
    localparam logic [1:0] SEL_CTRL  = 2'd0;
    localparam logic [1:0] SEL_START = 2'd1;
    localparam logic [1:0] SEL_CMP   = 2'd2;

    // control word bit positions
    localparam int CTRL_RUN_BIT    = 0;
    localparam int CTRL_RESTART_BIT = 1;

endpackage

// File: rtl/pwm_reg_bank.sv
module pwm_reg_bank
    import pwm_timer_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             halt_i,
    output logic             run_o,
    output logic             restart_o,
    output logic             start_o,
    output logic [WIDTH-1:0] start_val_o,
    output logic [WIDTH-1:0] cmp_val_o
);

    typedef struct packed {
        logic             run;
        logic             restart;
        logic [WIDTH-1:0] start_val;
        logic [WIDTH-1:0] cmp_val;
    } regs_t;

    regs_t regs_d, regs_q;
    logic  start_d;

    always_comb begin
        regs_d  = regs_q;
        start_d = 1'b0;
        if (halt_i) begin
            regs_d.run = 1'b0;
        end
        if (wr_en) begin
            case (wr_addr)
                SEL_CTRL: begin
                    start_d        = wr_data[CTRL_RUN_BIT] && !regs_d.run;
                    regs_d.run     = wr_data[CTRL_RUN_BIT];
                    regs_d.restart = wr_data[CTRL_RESTART_BIT];
                end
                SEL_START: regs_d.start_val = wr_data;
                SEL_CMP:   regs_d.cmp_val   = wr_data;
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign run_o       = regs_q.run;
    assign restart_o   = regs_q.restart;
    assign start_o     = start_d;
    assign start_val_o = regs_q.start_val;
    assign cmp_val_o   = regs_q.cmp_val;

    // R11: a halt with no concurrent control write leaves the timer stopped
    a_r11_halt_clears_run: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_i && !(wr_en && wr_addr == SEL_CTRL)) |=> !run_o);

    // R2: the unused select code leaves every register unchanged
    a_r2_spare_code_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd3 && !halt_i) |=>
            ($stable(start_val_o) && $stable(cmp_val_o) && $stable(run_o) && $stable(restart_o)));

endmodule

// File: rtl/pwm_count_core.sv
module pwm_count_core #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic             start_i,
    input  logic [WIDTH-1:0] start_val_i,
    output logic [WIDTH-1:0] cnt_o,
    output logic [WIDTH-1:0] cnt_next_o,
    output logic             wrap_o,
    output logic             step_o,
    output logic             halt_o
);

    localparam logic [WIDTH-1:0] CNT_TOP = '1;

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } core_t;

    core_t core_d, core_q;
    logic  at_top, advance, wrap, step, halt;

    always_comb begin
        at_top  = (core_q.cnt == CNT_TOP);
        halt    = run_i && !restart_i && at_top;
        advance = run_i && !halt && !start_i;
        wrap    = advance && at_top;
        step    = advance && !at_top;

        core_d = core_q;
        if (start_i || wrap) begin
            core_d.cnt = start_val_i;
        end else if (step) begin
            core_d.cnt = core_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '0;
        end else begin
            core_q <= core_d;
        end
    end

    assign cnt_o      = core_q.cnt;
    assign cnt_next_o = core_d.cnt;
    assign wrap_o     = wrap;
    assign step_o     = step;
    assign halt_o     = halt;

    a_r3_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (cnt_o == $past(start_val_i)));

    a_r4_counts_up: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !start_i && cnt_o != CNT_TOP) |=> (cnt_o == $past(cnt_o) + 1'b1));

    a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i && !start_i) |=> $stable(cnt_o));

    a_r5_wrap_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && restart_i && !start_i && cnt_o == CNT_TOP) |=> (cnt_o == $past(start_val_i)));

    a_r11_holds_top: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_o && !start_i) |=> (cnt_o == CNT_TOP));

endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             wrap_i,
    input  logic             step_i,
    input  logic [WIDTH-1:0] cnt_next_i,
    input  logic [WIDTH-1:0] cmp_val_i,
    output logic             pwm_o
);

    typedef struct packed {
        logic level;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d = out_q;
        if (start_i) begin
            out_d.level = 1'b0;
        end else if (wrap_i) begin
            out_d.level = 1'b1;          // wrap wins over a coincident compare hit
        end else if (step_i && cnt_next_i == cmp_val_i) begin
            out_d.level = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign pwm_o = out_q.level;

    a_r5_rise_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_i && !start_i) |=> pwm_o);

    a_r3_low_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !pwm_o);

    a_r6_fall_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !start_i && cnt_next_i == cmp_val_i) |=> !pwm_o);

    a_r4_level_held: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !wrap_i && !step_i) |=> $stable(pwm_o));

endmodule

// File: rtl/pwm_reload_timer.sv
module pwm_reload_timer #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] count_o,
    output logic             pwm_o
);

    logic             run, restart, start, halt, wrap, step;
    logic [WIDTH-1:0] start_val, cmp_val, cnt_next;

    pwm_reg_bank #(.WIDTH(WIDTH)) regs_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .halt_i      (halt),
        .run_o       (run),
        .restart_o   (restart),
        .start_o     (start),
        .start_val_o (start_val),
        .cmp_val_o   (cmp_val)
    );

    pwm_count_core #(.WIDTH(WIDTH)) core_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (run),
        .restart_i   (restart),
        .start_i     (start),
        .start_val_i (start_val),
        .cnt_o       (count_o),
        .cnt_next_o  (cnt_next),
        .wrap_o      (wrap),
        .step_o      (step),
        .halt_o      (halt)
    );

    pwm_out_stage #(.WIDTH(WIDTH)) out_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .wrap_i     (wrap),
        .step_i     (step),
        .cnt_next_i (cnt_next),
        .cmp_val_i  (cmp_val),
        .pwm_o      (pwm_o)
    );

    // R7: a start-value write alone never moves a running count off its step
    a_r7_start_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd1 && run && !halt && count_o != '1) |=>
            (count_o == $past(count_o) + 1'b1));

    // R12: equal start and compare values keep the output high after a wrap
    a_r12_wrap_precedence: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_o && run && restart && cmp_val == start_val && !start && !wr_en) |=> pwm_o);

endmodule

// File: tb/pwm_reload_timer_tb_top.sv
module pwm_reload_timer_tb_top;

    localparam int W   = 8;
    localparam int TOP = 255;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         wr_en;
    logic [1:0]   wr_addr;
    logic [W-1:0] wr_data;
    logic [W-1:0] count_o;
    logic         pwm_o;

    int errors = 0;
    int checks = 0;
    int cycles = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    pwm_reload_timer #(.WIDTH(W)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .count_o (count_o),
        .pwm_o   (pwm_o)
    );

    // behavioural reference state
    int m_cnt, m_pwm, m_run, m_rel, m_load, m_match;

    always @(posedge clk or negedge rst_n) begin
        int  n_cnt, n_pwm;
        bit  hold_top, go;
        if (!rst_n) begin
            m_cnt = 0; m_pwm = 0; m_run = 0; m_rel = 0; m_load = 0; m_match = 0;
        end else begin
            hold_top = (m_run != 0) && (m_rel == 0) && (m_cnt == TOP);
            if (hold_top) m_run = 0;
            go = wr_en && wr_addr == 2'd0 && wr_data[0] && (m_run == 0);
            n_cnt = m_cnt;
            n_pwm = m_pwm;
            if (go) begin
                n_cnt = m_load; n_pwm = 0;
            end else if (m_run != 0) begin
                if (m_cnt == TOP) begin
                    n_cnt = m_load; n_pwm = 1;
                end else begin
                    n_cnt = m_cnt + 1;
                    if (n_cnt == m_match) n_pwm = 0;
                end
            end
            m_cnt = n_cnt;
            m_pwm = n_pwm;
            if (wr_en) begin
                if (wr_addr == 2'd0) begin
                    m_run = wr_data[0];
                    m_rel = wr_data[1];
                end else if (wr_addr == 2'd1) begin
                    m_load = wr_data;
                end else if (wr_addr == 2'd2) begin
                    m_match = wr_data;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n === 1'b1 && !done) begin
            check(int'(count_o) == m_cnt, "R4 count", int'(count_o), m_cnt);
            check(int'(pwm_o) == m_pwm, "R6 level", int'(pwm_o), m_pwm);
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] a, input int d);
        wr_en   = 1'b1;
        wr_addr = a;
        wr_data = d[W-1:0];
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_at(input int v, input bit lvl);
        while (!(int'(count_o) == v && pwm_o == lvl)) @(negedge clk);
    endtask

    task automatic run_len(input bit lvl, output int n);
        n = 0;
        while (pwm_o == lvl) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int n;
        int lows;
        rst_n   = 1'b0;
        wr_en   = 1'b0;
        wr_addr = '0;
        wr_data = '0;
        repeat (3) @(negedge clk);
        check(count_o == 0, "R1 count", int'(count_o), 0);
        check(pwm_o == 0, "R1 level", int'(pwm_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // spare code 3 must do nothing: timer stays idle at zero
        wr(2'd3, 8'hFF);
        repeat (2) @(negedge clk);
        check(count_o == 0 && pwm_o == 0, "R2 spare code", int'(count_o), 0);

        // steady settings via codes 1, 2, 0
        wr(2'd1, 200);
        wr(2'd2, 230);
        wr(2'd0, 3);
        check(count_o == 200, "R3 start count", int'(count_o), 200);
        check(pwm_o == 0, "R3 start level", int'(pwm_o), 0);
        wait_at(200, 1);
        run_len(1'b1, n); check(n == 30, "R6 high time", n, 30);
        run_len(1'b0, n); check(n == 26, "R6 low time", n, 26);

        // R8: raise compare then lower it above the count during high phase
        wr(2'd2, 240);
        wait_at(210, 1);
        wr(2'd2, 220);
        run_len(1'b1, n); check(n == 9, "R8 shortened high", n, 9);

        // R9: compare dropped below the count while high
        wr(2'd2, 240);
        wait_at(230, 1);
        wr(2'd2, 215);
        run_len(1'b1, n); check(n == 40, "R9 stretched high", n, 40);
        run_len(1'b0, n); check(n == 41, "R9 following low", n, 41);

        // R10: compare write during the low phase
        wait_at(240, 0);
        wr(2'd2, 250);
        run_len(1'b0, n); check(n == 15, "R10 low undisturbed", n, 15);
        run_len(1'b1, n); check(n == 50, "R10 next high", n, 50);

        // R7: new start value used only at the next wrap
        wr(2'd1, 100);
        check(count_o == 251, "R7 count continues", int'(count_o), 251);
        wait_at(255, 0);
        @(negedge clk);
        check(count_o == 100, "R7 wrap count", int'(count_o), 100);
        check(pwm_o == 1, "R5 wrap level", int'(pwm_o), 1);

        // R4: stop freezes
        wr(2'd0, 2);
        repeat (5) @(negedge clk);
        check(count_o == 101, "R4 frozen count", int'(count_o), 101);
        check(pwm_o == 1, "R4 frozen level", int'(pwm_o), 1);

        // R12: compare equal to start value
        wr(2'd2, 100);
        wr(2'd0, 3);
        wait_at(100, 1);
        lows = 0;
        for (int i = 0; i < 400; i++) begin
            if (pwm_o == 1'b0) lows++;
            @(negedge clk);
        end
        check(lows == 0, "R12 always high", lows, 0);

        // R11: auto-restart off
        wr(2'd0, 1);
        wait_at(255, 1);
        repeat (4) @(negedge clk);
        check(count_o == 255, "R11 held count", int'(count_o), 255);
        check(pwm_o == 1, "R11 held level", int'(pwm_o), 1);
        wr(2'd0, 3);
        check(count_o == 100, "R11 restart count", int'(count_o), 100);
        check(pwm_o == 0, "R11 restart level", int'(pwm_o), 0);
        repeat (3) @(negedge clk);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule